// File: doc/BRIEF.md
# Oscillator Configuration Register File

This block holds the two byte-wide control registers of a programmable clock source and sits behind a plain register port made of an address, write data, a write strobe and a combinational read-data output. One register carries the modulation-rate select, the power-down output mode and a divider exponent. The other carries the modulation-amplitude select, an output-enable bit, a write-control bit and the low three bits of the device's serial bus address. The block decodes these fields onto dedicated outputs and builds the full 7-bit bus address from a fixed upper nibble and the register bits.

A nonvolatile shadow bank is modelled as a register pair with a busy handshake. A power-on reset (`por_n`) loads that bank with factory values. A functional reset (`rst_n`) reloads the working registers from the bank. The write-control bit selects the copy policy. When it is clear, every register write is followed by a copy of both working registers into the bank. When it is set, only a write to the commit address starts a copy. Copy requests that arrive while a copy is under way are merged into a single pending copy. That copy runs when the bank is free and takes the register contents current at that moment.

Top module: `osc_cfg_regs`

## Requirements
- R1: A read of address 02h returns the rate/divider register and a read of 0Dh returns the address/control register. Every other address, the commit address 3Fh included, reads 00h.
- R2: Bit 4 of both registers is reserved. It always reads 0, and writing 1 to it has no effect.
- R3: A write to an address other than 02h, 0Dh or 3Fh changes no register, no output and no nonvolatile content, and it does not raise `busy_o`.
- R4: While the write-control bit (bit 3 of 0Dh) is 0 after a write, each write to 02h or 0Dh requests a copy of both registers into the nonvolatile bank. A write to 0Dh is judged by the value it writes.
- R5: While the write-control bit is 1, register writes request no copy and leave the bank unchanged. A write of any data to 3Fh requests a copy.
- R6: `busy_o` rises in the cycle after a copy request and stays high until the copy completes. A copy starts one cycle after its request, or one cycle after the previous copy ends, and lasts COMMIT_CYCLES cycles. Several requests made during a copy produce one further copy, and that copy holds the latest register values.
- R7: While `por_n` is low, the bank loads the factory values with bits 5:4 of the 02h image and bit 4 of the 0Dh image cleared. While `rst_n` is low, the working registers load the bank contents.
- R8: `div_exp_o` equals bits 3:0 of 02h, except that values above 8 give 8.
- R9: `rate_sel_o` = 02h[7:6], `pd_low_o` = 02h[5], `amp_sel_o` = 0Dh[7:6], `oe_bit_o` = 0Dh[5], `wc_o` = 0Dh[3].
- R10: `bus_addr_o` = {BUS_ADDR_HI, 0Dh[2:0]}, with the register bits in the three least significant positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; loads factory values into the nonvolatile bank |
| rst_n | input | 1 | Synchronous functional reset, active low; reloads the working registers from the bank |
| cfg_addr_i | input | ADDR_W (8) | Register address |
| cfg_wdata_i | input | 8 | Write data |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_rdata_o | output | 8 | Read data for `cfg_addr_i` (combinational) |
| busy_o | output | 1 | A copy to the nonvolatile bank is pending or in progress |
| rate_sel_o | output | 2 | Modulation-rate select |
| pd_low_o | output | 1 | Power-down output mode: 1 drives low, 0 floats |
| div_exp_o | output | 4 | Divider exponent, clamped to 8 |
| amp_sel_o | output | 2 | Modulation-amplitude select |
| oe_bit_o | output | 1 | Output-enable register bit |
| wc_o | output | 1 | Write-control bit |
| bus_addr_o | output | BUS_HI_W+3 (7) | Serial bus address of the device |

## Verification
The bench probes the commit policy at its edges. A 0Dh write that sets the write-control bit must not copy, and one that clears it must copy. A design that judged such a write by the old bit value would copy, or skip the copy, and a later reset-reload would expose the wrong register contents. A burst of writes made during a copy must give exactly one more copy holding the last value. A design that dropped the queued request would reload stale data, and one that started a copy while the bank was busy would corrupt the shadow or change the busy timing. Divider values above 8, reserved-bit writes and unmapped writes are driven as well, so a missing clamp, a stored reserved bit or a stray decode shows up at the outputs.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;

    localparam int REG_W    = 8;
    localparam int WC_BIT   = 3;
    localparam int RSV_BIT  = 4;

    // writable bits of both registers (bit 4 reserved)
    localparam logic [REG_W-1:0] WMASK       = 8'hEF;
    // power-on image of the divider register also drops the power-down mode bit
    localparam logic [REG_W-1:0] PRE_POR_MASK = 8'hCF;

    localparam logic [3:0] DIV_MAX = 4'd8;

    typedef struct packed {
        logic [REG_W-1:0] pre;   // rate / power-down mode / divider exponent
        logic [REG_W-1:0] ctl;   // amplitude / output enable / write control / address
    } cfg_pair_t;

endpackage

// File: rtl/osc_cfg_nvbank.sv
module osc_cfg_nvbank
    import osc_cfg_pkg::*;
#(
    parameter int               COMMIT_CYCLES = 6,
    parameter logic [REG_W-1:0] FACTORY_PRE   = 8'hFA,
    parameter logic [REG_W-1:0] FACTORY_CTL   = 8'h15
) (
    input  logic      clk,
    input  logic      por_n,
    input  logic      start_i,
    input  cfg_pair_t data_i,
    output cfg_pair_t shadow_o,
    output logic      busy_o
);

    localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam cfg_pair_t FACT_CLEAN = {FACTORY_PRE & PRE_POR_MASK, FACTORY_CTL & WMASK};

    typedef struct packed {
        cfg_pair_t  shadow;
        cfg_pair_t  staged;
        logic       busy;
        logic [CNT_W-1:0] cnt;
    } nv_state_t;

    nv_state_t nv_d, nv_q;

    always_comb begin
        nv_d = nv_q;
        if (nv_q.busy) begin
            if (nv_q.cnt == '0) begin
                nv_d.busy   = 1'b0;
                nv_d.shadow = nv_q.staged;
            end else begin
                nv_d.cnt = nv_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            nv_d.staged = data_i;
            nv_d.busy   = 1'b1;
            nv_d.cnt    = CNT_W'(COMMIT_CYCLES - 1);
        end
        if (!por_n) begin
            nv_d.shadow = FACT_CLEAN;
            nv_d.staged = FACT_CLEAN;
            nv_d.busy   = 1'b0;
            nv_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        nv_q <= nv_d;
    end

    assign shadow_o = nv_q.shadow;
    assign busy_o   = nv_q.busy;

    // R6: a copy is never launched on top of a running one
    assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!por_n)
        start_i |-> !busy_o);

    // R5: the bank content only moves at the end of a copy
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        !busy_o |=> $stable(shadow_o));

endmodule

// File: rtl/osc_cfg_decode.sv
module osc_cfg_decode
    import osc_cfg_pkg::*;
#(
    parameter int                BUS_HI_W    = 4,
    parameter logic [BUS_HI_W-1:0] BUS_ADDR_HI = 4'hB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_pair_t          regs_i,
    output logic [1:0]         rate_sel_o,
    output logic               pd_low_o,
    output logic [3:0]         div_exp_o,
    output logic [1:0]         amp_sel_o,
    output logic               oe_bit_o,
    output logic               wc_o,
    output logic [BUS_HI_W+2:0] bus_addr_o
);

    always_comb begin
        rate_sel_o = regs_i.pre[7:6];
        pd_low_o   = regs_i.pre[5];
        div_exp_o  = (regs_i.pre[3:0] > DIV_MAX) ? DIV_MAX : regs_i.pre[3:0];
        amp_sel_o  = regs_i.ctl[7:6];
        oe_bit_o   = regs_i.ctl[5];
        wc_o       = regs_i.ctl[WC_BIT];
        bus_addr_o = {BUS_ADDR_HI, regs_i.ctl[2:0]};
    end

    // R8: the exponent never exceeds the clamp
    assert_div_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_exp_o <= DIV_MAX);

    // R2: reserved bits never hold a 1 in the working registers
    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_i.pre[RSV_BIT] && !regs_i.ctl[RSV_BIT]);

endmodule

// File: rtl/osc_cfg_regs.sv
module osc_cfg_regs
    import osc_cfg_pkg::*;
#(
    parameter int                  ADDR_W        = 8,
    parameter logic [ADDR_W-1:0]   PRE_ADDR      = 8'h02,
    parameter logic [ADDR_W-1:0]   CTL_ADDR      = 8'h0D,
    parameter logic [ADDR_W-1:0]   CMD_ADDR      = 8'h3F,
    parameter int                  BUS_HI_W      = 4,
    parameter logic [BUS_HI_W-1:0] BUS_ADDR_HI   = 4'hB,
    parameter int                  COMMIT_CYCLES = 6,
    parameter logic [7:0]          FACTORY_PRE   = 8'hFA,
    parameter logic [7:0]          FACTORY_CTL   = 8'h15
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [7:0]         cfg_wdata_i,
    input  logic               cfg_wr_i,
    output logic [7:0]         cfg_rdata_o,
    output logic               busy_o,
    output logic [1:0]         rate_sel_o,
    output logic               pd_low_o,
    output logic [3:0]         div_exp_o,
    output logic [1:0]         amp_sel_o,
    output logic               oe_bit_o,
    output logic               wc_o,
    output logic [BUS_HI_W+2:0] bus_addr_o
);

    typedef struct packed {
        cfg_pair_t regs;
        logic      pend;
    } top_state_t;

    top_state_t st_d, st_q;
    cfg_pair_t  shadow;
    logic       nv_busy;
    logic       nv_start;
    logic       copy_req;
    logic       hit_pre, hit_ctl, hit_cmd;

    assign hit_pre = (cfg_addr_i == PRE_ADDR);
    assign hit_ctl = (cfg_addr_i == CTL_ADDR);
    assign hit_cmd = (cfg_addr_i == CMD_ADDR);

    always_comb begin
        st_d     = st_q;
        copy_req = 1'b0;
        nv_start = st_q.pend && !nv_busy;
        if (cfg_wr_i) begin
            if (hit_pre) begin
                st_d.regs.pre = cfg_wdata_i & WMASK;
                copy_req      = !st_q.regs.ctl[WC_BIT];
            end else if (hit_ctl) begin
                st_d.regs.ctl = cfg_wdata_i & WMASK;
                copy_req      = !cfg_wdata_i[WC_BIT];
            end else if (hit_cmd) begin
                copy_req      = 1'b1;
            end
        end
        st_d.pend = copy_req || (st_q.pend && nv_busy);
        if (!rst_n) begin
            st_d.regs = shadow;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata_o = '0;
        if (hit_pre)      cfg_rdata_o = st_q.regs.pre;
        else if (hit_ctl) cfg_rdata_o = st_q.regs.ctl;
    end

    assign busy_o = st_q.pend || nv_busy;

    osc_cfg_nvbank #(
        .COMMIT_CYCLES (COMMIT_CYCLES),
        .FACTORY_PRE   (FACTORY_PRE),
        .FACTORY_CTL   (FACTORY_CTL)
    ) u_nvbank (
        .clk      (clk),
        .por_n    (por_n),
        .start_i  (nv_start),
        .data_i   (st_q.regs),
        .shadow_o (shadow),
        .busy_o   (nv_busy)
    );

    osc_cfg_decode #(
        .BUS_HI_W    (BUS_HI_W),
        .BUS_ADDR_HI (BUS_ADDR_HI)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .regs_i     (st_q.regs),
        .rate_sel_o (rate_sel_o),
        .pd_low_o   (pd_low_o),
        .div_exp_o  (div_exp_o),
        .amp_sel_o  (amp_sel_o),
        .oe_bit_o   (oe_bit_o),
        .wc_o       (wc_o),
        .bus_addr_o (bus_addr_o)
    );

    // R6: a copy request shows as busy in the following cycle
    assert_busy_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |=> busy_o);

    // R3: unmapped writes leave the registers alone
    assert_unmapped_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !hit_pre && !hit_ctl && !hit_cmd) |=> $stable(st_q.regs));

    // R5: with write control set and nothing queued, a divider write stays idle
    assert_wc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && hit_pre && st_q.regs.ctl[WC_BIT] && !busy_o) |=> !busy_o);

    // R7: functional reset reloads the working pair from the bank
    assert_reload_R7: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (st_q.regs == $past(shadow)));

endmodule

// File: tb/osc_cfg_regs_test.sv
module osc_cfg_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int COMMIT     = 6;
    localparam logic [7:0] FP = 8'hFA;
    localparam logic [7:0] FC = 8'h15;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr = 1'b0;
    logic [7:0] rdata;
    logic       busy;
    logic [1:0] rate_sel, amp_sel;
    logic       pd_low, oe_bit, wc;
    logic [3:0] div_exp;
    logic [6:0] bus_addr;

    int total = 0;
    int fails = 0;
    bit started = 1'b0;

    // reference model state
    logic [7:0] m_pre, m_ctl, m_sh_pre, m_sh_ctl, m_st_pre, m_st_ctl;
    bit         m_pend = 1'b0;
    int         m_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osc_cfg_regs #(.COMMIT_CYCLES(COMMIT), .FACTORY_PRE(FP), .FACTORY_CTL(FC)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_wr_i(wr),
        .cfg_rdata_o(rdata), .busy_o(busy),
        .rate_sel_o(rate_sel), .pd_low_o(pd_low), .div_exp_o(div_exp),
        .amp_sel_o(amp_sel), .oe_bit_o(oe_bit), .wc_o(wc), .bus_addr_o(bus_addr)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        logic [7:0] o_pre, o_ctl, o_shp, o_shc;
        bit o_pend, req;
        int o_left;
        o_pre = m_pre; o_ctl = m_ctl; o_shp = m_sh_pre; o_shc = m_sh_ctl;
        o_pend = m_pend; o_left = m_left;
        if (!por_n) begin
            m_sh_pre = FP & 8'hCF; m_sh_ctl = FC & 8'hEF; m_left = 0;
        end else if (o_left > 0) begin
            m_left = o_left - 1;
            if (m_left == 0) begin m_sh_pre = m_st_pre; m_sh_ctl = m_st_ctl; end
        end else if (o_pend) begin
            m_left = COMMIT; m_st_pre = o_pre; m_st_ctl = o_ctl;
        end
        if (!rst_n) begin
            m_pre = o_shp; m_ctl = o_shc; m_pend = 1'b0;
        end else begin
            req = 1'b0;
            if (wr) begin
                if (addr == 8'h02) begin m_pre = wdata & 8'hEF; req = !o_ctl[3]; end
                else if (addr == 8'h0D) begin m_ctl = wdata & 8'hEF; req = !wdata[3]; end
                else if (addr == 8'h3F) req = 1'b1;
            end
            m_pend = req || (o_pend && o_left > 0);
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (started) begin
            logic [7:0] e_rd;
            e_rd = (addr == 8'h02) ? m_pre : (addr == 8'h0D) ? m_ctl : 8'h00;
            check("R1", "rdata", rdata, e_rd);
            check("R6", "busy", busy, (m_pend || m_left > 0) ? 1 : 0);
            check("R9", "fields", {rate_sel, pd_low, amp_sel, oe_bit, wc},
                  {m_pre[7:6], m_pre[5], m_ctl[7:6], m_ctl[5], m_ctl[3]});
            check("R8", "div_exp", div_exp, (m_pre[3:0] > 4'd8) ? 8 : m_pre[3:0]);
            check("R10", "bus_addr", bus_addr, {4'hB, m_ctl[2:0]});
        end
    end

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); #1;
        wr = 1'b0; addr = 8'h00;
    endtask

    task automatic read_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        addr = a; #1;
        check(tag, "directed read", rdata, exp);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); #2;
            if (!busy) break;
        end
    endtask

    task automatic pulse_rst();
        @(negedge clk); #1; rst_n = 1'b0;
        @(negedge clk); @(negedge clk); #1; rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL R6 watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1; por_n = 1'b1; rst_n = 1'b1;
        started = 1'b1;
        // R7: power-on image with bits 5:4 of 02h and bit 4 of 0Dh cleared
        read_check(8'h02, 8'hCA, "R7");
        read_check(8'h0D, 8'h05, "R7");
        #1; check("R10", "bus_addr after por", bus_addr, 7'h5D);
        check("R8", "clamped exponent", div_exp, 8);
        // R2: reserved bit ignores writes
        write_reg(8'h02, 8'hFF);
        read_check(8'h02, 8'hEF, "R2");
        wait_idle();
        // R3: unmapped write
        write_reg(8'h40, 8'h12);
        #1; check("R3", "busy after unmapped write", busy, 0);
        read_check(8'h02, 8'hEF, "R3");
        read_check(8'h3F, 8'h00, "R1");
        // R4: auto copy with write control clear
        write_reg(8'h02, 8'h03);
        #1; check("R4", "busy after auto copy request", busy, 1);
        wait_idle();
        pulse_rst();
        read_check(8'h02, 8'h03, "R4");
        // R5: write control set, no copy without commit
        write_reg(8'h0D, 8'h2E);
        #1; check("R5", "busy after setting write control", busy, 0);
        write_reg(8'h02, 8'h47);
        #1; check("R5", "busy after held write", busy, 0);
        repeat (COMMIT + 2) @(negedge clk);
        pulse_rst();
        read_check(8'h02, 8'h03, "R5");
        read_check(8'h0D, 8'h05, "R5");
        write_reg(8'h0D, 8'h2E);
        write_reg(8'h02, 8'h47);
        write_reg(8'h3F, 8'h00);
        #1; check("R5", "busy after commit", busy, 1);
        wait_idle();
        pulse_rst();
        read_check(8'h02, 8'h47, "R5");
        read_check(8'h0D, 8'h2E, "R5");
        // R6: requests during a copy merge into one later copy
        write_reg(8'h0D, 8'h21);
        write_reg(8'h02, 8'h81);
        write_reg(8'h02, 8'h82);
        #1; check("R6", "busy while queued", busy, 1);
        wait_idle();
        pulse_rst();
        read_check(8'h02, 8'h82, "R6");
        read_check(8'h0D, 8'h21, "R6");
        // assorted writes across fields
        for (int k = 0; k < 10; k++) begin
            write_reg(8'h02, 8'(k * 37 + 5));
            write_reg(8'h0D, 8'(k * 53 + 1) & 8'hF7);
            wait_idle();
        end
        pulse_rst();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule